// File: doc/BRIEF.md
# Bus Source-ID Debug Capture Unit

This block observes a multiplexed external local bus and turns the cycles that carry real traffic into debug trace entries. Each bus cycle presents a 5-bit transaction source ID, an address latch strobe, a data valid strobe, 27 shared address/data lines and 5 dedicated low-address lines. The all-ones source ID is reserved: it marks a cycle in which the bus holds nothing worth recording. Any other ID, together with the address strobe, yields an address entry. Any other ID, together with the data strobe, yields a data entry.

All bus inputs are registered once before they are qualified. Entries go into a 16-deep trace FIFO. Each entry carries a kind bit, the source ID and a 32-bit payload. A host drains the FIFO through a ready/valid pop port. When the FIFO has no room, entries are dropped and a sticky overflow flag is raised; only a clear pulse lowers the flag.

A separate driver path produces the source-ID pins for the bus side. It forwards the current transaction's ID while a valid phase is on the bus, and outputs the reserved idle code at every other time.

Top module: `bus_trace_capture`

## Requirements
- R1: A synchronous active-high reset empties the FIFO (`pop_valid` low), clears `overflow` and sets `drv_src_id_out` to 5'h1F.
- R2: A sampled cycle with `bus_src_id` not equal to 5'h1F and `bus_ale` high produces an entry with `pop_kind` = 0, `pop_src` = that ID and `pop_payload` = {`bus_ad`, `bus_la`}. `bus_ad` is placed in payload bits [31:5], so address bit 0 in MSB-first numbering is `bus_ad[26]`. `bus_la` is placed in payload bits [4:0].
- R3: A sampled cycle with a non-reserved ID and `bus_dval` high produces an entry with `pop_kind` = 1, that ID, and `bus_ad` zero-extended to 32 bits.
- R4: A sampled cycle whose ID is 5'h1F produces no entry, whatever the strobes are.
- R5: When both strobes are high with a valid ID, two entries are written in the same cycle: the address entry first and the data entry after it.
- R6: An entry presented on the bus inputs before rising edge k is visible at the pop port after rising edge k+1 (one stage for sampling, one for the FIFO write).
- R7: Entries leave in arrival order. The head entry holds steady while `pop_ready` is low, and it is removed at a rising edge where `pop_valid` and `pop_ready` are both high.
- R8: The FIFO holds 16 entries. An entry that finds no free slot is dropped, the stored entries are kept intact, and `overflow` is set.
- R9: `overflow` stays set until `clr_ovf` is pulsed. If a drop and a clear fall in the same cycle, the drop wins.
- R10: While `enable` is low, no entry is written and `overflow` keeps its value.
- R11: `drv_src_id_out` equals `drv_src_id_in` one cycle after `drv_valid` is high. It is 5'h1F one cycle after `drv_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Capture enable, applied to the sampled cycle |
| clr_ovf | input | 1 | Pulse that clears the overflow flag |
| bus_src_id | input | 5 | Observed transaction source ID |
| bus_ale | input | 1 | Observed address latch strobe |
| bus_dval | input | 1 | Observed data valid strobe |
| bus_ad | input | 27 | Observed shared address/data lines |
| bus_la | input | 5 | Observed dedicated low-address lines |
| drv_valid | input | 1 | Driver mode: a valid phase is on the bus |
| drv_src_id_in | input | 5 | Driver mode: ID of the current transaction |
| drv_src_id_out | output | 5 | Driver mode: registered source-ID pin value |
| pop_ready | input | 1 | Host accepts the head entry |
| pop_valid | output | 1 | FIFO holds at least one entry |
| pop_kind | output | 1 | Head entry kind: 0 for address, 1 for data |
| pop_src | output | 5 | Head entry source ID |
| pop_payload | output | 32 | Head entry payload |
| overflow | output | 1 | Sticky flag: an entry was dropped |

## Verification
The assertions assume that `clr_ovf` is a single-cycle pulse and that `pop_ready` never removes an entry from an empty FIFO. They also assume that the host never expects a pop to make room for a push in the same cycle. The bench therefore changes every input only at the falling edge. It raises `pop_ready` only after it has seen `pop_valid` high, and it fills the FIFO with `pop_ready` held low. Each test returns the bus to the idle ID 5'h1F, so a check never races a leftover strobe.

// File: rtl/trace_pkg.sv
package trace_pkg;
    localparam int SRC_W = 5;
    localparam int AD_W  = 27;
    localparam int LA_W  = 5;
    localparam int PAY_W = AD_W + LA_W;
    localparam logic [SRC_W-1:0] SRC_IDLE = {SRC_W{1'b1}};

    typedef enum logic {
        ENT_ADDR = 1'b0,
        ENT_DATA = 1'b1
    } ent_kind_e;

    typedef struct packed {
        ent_kind_e          kind;
        logic [SRC_W-1:0]   src;
        logic [PAY_W-1:0]   payload;
    } trace_ent_t;
endpackage

// File: rtl/trace_sampler.sv
module trace_sampler
    import trace_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic [SRC_W-1:0]   src_id,
    input  logic               ale,
    input  logic               dval,
    input  logic [AD_W-1:0]    ad,
    input  logic [LA_W-1:0]    la,
    output logic               addr_req,
    output logic               data_req,
    output trace_ent_t         addr_ent,
    output trace_ent_t         data_ent
);
    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic             ale;
        logic             dval;
        logic [AD_W-1:0]  ad;
        logic [LA_W-1:0]  la;
    } samp_t;

    samp_t s_d, s_q;
    logic  id_live;

    always_comb begin
        s_d.src  = src_id;
        s_d.ale  = ale;
        s_d.dval = dval;
        s_d.ad   = ad;
        s_d.la   = la;

        id_live  = (s_q.src != SRC_IDLE);
        addr_req = enable && id_live && s_q.ale;
        data_req = enable && id_live && s_q.dval;

        addr_ent.kind    = ENT_ADDR;
        addr_ent.src     = s_q.src;
        addr_ent.payload = {s_q.ad, s_q.la};

        data_ent.kind    = ENT_DATA;
        data_ent.src     = s_q.src;
        data_ent.payload = {{(PAY_W-AD_W){1'b0}}, s_q.ad};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q      <= '0;
            s_q.src  <= SRC_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    // R4: a reserved ID in the sampled stage never asks the FIFO for a write
    assert_idle_no_req_R4: assert property (@(posedge clk) disable iff (rst)
        (s_q.src == SRC_IDLE) |-> (!addr_req && !data_req));
endmodule

// File: rtl/trace_fifo.sv
module trace_fifo
    import trace_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               push_a,
    input  trace_ent_t         ent_a,
    input  logic               push_b,
    input  trace_ent_t         ent_b,
    input  logic               clr_ovf,
    input  logic               pop_ready,
    output logic               pop_valid,
    output trace_ent_t         head,
    output logic               overflow,
    output logic [$clog2(DEPTH):0] level
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
        logic          ovf;
    } fifo_st_t;

    fifo_st_t   st_d, st_q;
    trace_ent_t mem [DEPTH];

    logic [CW-1:0] free_slots, n_req, n_acc;
    logic          w0, w1, drop, do_pop;
    logic [AW-1:0] wr_next1;
    trace_ent_t    first_ent, second_ent;

    always_comb begin
        st_d       = st_q;
        free_slots = CW'(DEPTH) - st_q.cnt;
        n_req      = CW'(push_a) + CW'(push_b);
        first_ent  = push_a ? ent_a : ent_b;
        second_ent = ent_b;
        w0         = (n_req != '0) && (free_slots != '0);
        w1         = (n_req == CW'(2)) && (free_slots >= CW'(2));
        n_acc      = CW'(w0) + CW'(w1);
        drop       = (n_req > n_acc);
        do_pop     = (st_q.cnt != '0) && pop_ready;
        wr_next1   = st_q.wr + AW'(1);

        st_d.wr  = st_q.wr + AW'(n_acc);
        st_d.rd  = st_q.rd + AW'(do_pop);
        st_d.cnt = st_q.cnt + n_acc - CW'(do_pop);
        if (clr_ovf) st_d.ovf = 1'b0;
        if (drop)    st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst) begin
            if (w0) mem[st_q.wr]  <= first_ent;
            if (w1) mem[wr_next1] <= second_ent;
        end
    end

    assign pop_valid = (st_q.cnt != '0);
    assign head      = mem[st_q.rd];
    assign overflow  = st_q.ovf;
    assign level     = st_q.cnt;

    // R8: occupancy never exceeds the depth
    assert_level_bound_R8: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= CW'(DEPTH));
    // R8: a request meeting a full FIFO raises the flag
    assert_full_drop_flags_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt == CW'(DEPTH) && (push_a || push_b)) |=> st_q.ovf);
    // R9: the flag only falls after a clear pulse
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q.ovf && !clr_ovf) |=> st_q.ovf);
    // R5: a dual request with room for two grows occupancy by two when idle on pop
    assert_dual_write_R5: assert property (@(posedge clk) disable iff (rst)
        (push_a && push_b && !pop_ready && st_q.cnt <= CW'(DEPTH-2))
        |=> (st_q.cnt == $past(st_q.cnt) + CW'(2)));
endmodule

// File: rtl/srcid_driver.sv
module srcid_driver
    import trace_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             drv_valid,
    input  logic [SRC_W-1:0] drv_src_id_in,
    output logic [SRC_W-1:0] drv_src_id_out
);
    typedef struct packed {
        logic [SRC_W-1:0] pin;
    } drv_st_t;

    drv_st_t d_d, d_q;

    always_comb begin
        d_d.pin = drv_valid ? drv_src_id_in : SRC_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) d_q.pin <= SRC_IDLE;
        else     d_q     <= d_d;
    end

    assign drv_src_id_out = d_q.pin;

    // R11: no valid phase means idle code on the pins next cycle
    assert_drv_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !drv_valid |=> (drv_src_id_out == SRC_IDLE));
    // R11: a valid phase forwards the ID next cycle
    assert_drv_forward_R11: assert property (@(posedge clk) disable iff (rst)
        drv_valid |=> (drv_src_id_out == $past(drv_src_id_in)));
endmodule

// File: rtl/bus_trace_capture.sv
module bus_trace_capture
    import trace_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         clr_ovf,
    input  logic [4:0]   bus_src_id,
    input  logic         bus_ale,
    input  logic         bus_dval,
    input  logic [26:0]  bus_ad,
    input  logic [4:0]   bus_la,
    input  logic         drv_valid,
    input  logic [4:0]   drv_src_id_in,
    output logic [4:0]   drv_src_id_out,
    input  logic         pop_ready,
    output logic         pop_valid,
    output logic         pop_kind,
    output logic [4:0]   pop_src,
    output logic [31:0]  pop_payload,
    output logic         overflow
);
    localparam int LW = $clog2(FIFO_DEPTH) + 1;

    logic           addr_req, data_req;
    trace_ent_t     addr_ent, data_ent, head;
    logic [LW-1:0]  level;

    trace_sampler u_sampler (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .src_id   (bus_src_id),
        .ale      (bus_ale),
        .dval     (bus_dval),
        .ad       (bus_ad),
        .la       (bus_la),
        .addr_req (addr_req),
        .data_req (data_req),
        .addr_ent (addr_ent),
        .data_ent (data_ent)
    );

    trace_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push_a    (addr_req),
        .ent_a     (addr_ent),
        .push_b    (data_req),
        .ent_b     (data_ent),
        .clr_ovf   (clr_ovf),
        .pop_ready (pop_ready),
        .pop_valid (pop_valid),
        .head      (head),
        .overflow  (overflow),
        .level     (level)
    );

    srcid_driver u_driver (
        .clk            (clk),
        .rst            (rst),
        .drv_valid      (drv_valid),
        .drv_src_id_in  (drv_src_id_in),
        .drv_src_id_out (drv_src_id_out)
    );

    assign pop_kind    = head.kind;
    assign pop_src     = head.src;
    assign pop_payload = head.payload;

    // R4: no entry that reaches the host carries the reserved ID
    assert_no_idle_entry_R4: assert property (@(posedge clk) disable iff (rst)
        pop_valid |-> (pop_src != SRC_IDLE));
    // R10: with capture disabled, occupancy cannot grow
    assert_disabled_no_growth_R10: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (level <= $past(level)));
    // R10: with capture disabled and no clear, the flag holds
    assert_disabled_ovf_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!enable && !clr_ovf) |=> $stable(overflow));
endmodule

// File: tb/tb_bus_trace_capture.sv
`timescale 1ns/1ps
module tb_bus_trace_capture;
    logic        clk = 1'b0;
    logic        rst, enable, clr_ovf;
    logic [4:0]  bus_src_id;
    logic        bus_ale, bus_dval;
    logic [26:0] bus_ad;
    logic [4:0]  bus_la;
    logic        drv_valid;
    logic [4:0]  drv_src_id_in, drv_src_id_out;
    logic        pop_ready, pop_valid, pop_kind, overflow;
    logic [4:0]  pop_src;
    logic [31:0] pop_payload;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    bus_trace_capture dut (
        .clk(clk), .rst(rst), .enable(enable), .clr_ovf(clr_ovf),
        .bus_src_id(bus_src_id), .bus_ale(bus_ale), .bus_dval(bus_dval),
        .bus_ad(bus_ad), .bus_la(bus_la),
        .drv_valid(drv_valid), .drv_src_id_in(drv_src_id_in),
        .drv_src_id_out(drv_src_id_out),
        .pop_ready(pop_ready), .pop_valid(pop_valid), .pop_kind(pop_kind),
        .pop_src(pop_src), .pop_payload(pop_payload), .overflow(overflow)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_idle();
        bus_src_id = 5'h1F; bus_ale = 1'b0; bus_dval = 1'b0;
        bus_ad = '0; bus_la = '0;
    endtask

    // present one bus cycle, then idle; returns at the falling edge after the sample edge
    task automatic bus_cycle(input logic [4:0] id, input logic a, input logic d,
                             input logic [26:0] ad, input logic [4:0] la);
        bus_src_id = id; bus_ale = a; bus_dval = d; bus_ad = ad; bus_la = la;
        @(negedge clk);
        bus_idle();
    endtask

    task automatic pop_expect(input string tag, input logic k, input logic [4:0] s,
                              input logic [31:0] p);
        chk({tag, " valid"}, 64'(pop_valid), 64'(1));
        chk({tag, " kind"}, 64'(pop_kind), 64'(k));
        chk({tag, " src"}, 64'(pop_src), 64'(s));
        chk({tag, " payload"}, 64'(pop_payload), 64'(p));
        pop_ready = 1'b1;
        @(negedge clk);
        pop_ready = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R1 pop_valid after reset", 64'(pop_valid), 64'(0));
        chk("R1 overflow after reset", 64'(overflow), 64'(0));
        chk("R1 driver pins after reset", 64'(drv_src_id_out), 64'(5'h1F));
    endtask

    task automatic t_addr();
        logic [26:0] ad = 27'h5A5A5A5;
        logic [4:0]  la = 5'h13;
        bus_cycle(5'h03, 1'b1, 1'b0, ad, la);
        chk("R6 not visible after one edge", 64'(pop_valid), 64'(0));
        @(negedge clk);
        pop_expect("R2 address entry", 1'b0, 5'h03, {ad, la});
        chk("R2 fifo empty after pop", 64'(pop_valid), 64'(0));
    endtask

    task automatic t_data();
        bus_cycle(5'h1E, 1'b0, 1'b1, 27'h7FFFFFF, 5'h1F);
        @(negedge clk);
        pop_expect("R3 data entry", 1'b1, 5'h1E, {5'b0, 27'h7FFFFFF});
    endtask

    task automatic t_idle_id();
        bus_cycle(5'h1F, 1'b1, 1'b1, 27'h1234567, 5'h01);
        repeat (2) @(negedge clk);
        chk("R4 reserved id gives no entry", 64'(pop_valid), 64'(0));
    endtask

    task automatic t_both();
        logic [26:0] ad = 27'h0ABCDEF;
        bus_cycle(5'h07, 1'b1, 1'b1, ad, 5'h0C);
        @(negedge clk);
        pop_expect("R5 first is address", 1'b0, 5'h07, {ad, 5'h0C});
        pop_expect("R5 second is data", 1'b1, 5'h07, {5'b0, ad});
        chk("R5 only two entries", 64'(pop_valid), 64'(0));
    endtask

    task automatic t_order();
        bus_src_id = 5'h01; bus_dval = 1'b1; bus_ad = 27'h11;
        @(negedge clk);
        bus_src_id = 5'h02; bus_ad = 27'h22;
        @(negedge clk);
        bus_src_id = 5'h03; bus_ad = 27'h33;
        @(negedge clk);
        bus_idle();
        repeat (3) @(negedge clk);
        chk("R7 head held while not ready", 64'(pop_src), 64'(5'h01));
        pop_expect("R7 order 1", 1'b1, 5'h01, 32'h11);
        pop_expect("R7 order 2", 1'b1, 5'h02, 32'h22);
        pop_expect("R7 order 3", 1'b1, 5'h03, 32'h33);
    endtask

    task automatic t_full_and_disable();
        for (int i = 0; i < 18; i++) begin
            bus_src_id = 5'(i); bus_ale = 1'b1; bus_ad = 27'(i * 3); bus_la = 5'(i);
            @(negedge clk);
        end
        bus_idle();
        @(negedge clk);
        chk("R8 overflow set on drop", 64'(overflow), 64'(1));
        for (int i = 0; i < 16; i++)
            pop_expect("R8 kept entry", 1'b0, 5'(i), {27'(i * 3), 5'(i)});
        chk("R8 dropped entries absent", 64'(pop_valid), 64'(0));
        chk("R9 overflow sticky after drain", 64'(overflow), 64'(1));
        enable = 1'b0;
        bus_cycle(5'h04, 1'b1, 1'b1, 27'h5, 5'h5);
        repeat (2) @(negedge clk);
        chk("R10 no entry while disabled", 64'(pop_valid), 64'(0));
        chk("R10 overflow held while disabled", 64'(overflow), 64'(1));
        enable = 1'b1;
        clr_ovf = 1'b1;
        @(negedge clk);
        clr_ovf = 1'b0;
        chk("R9 clear pulse drops flag", 64'(overflow), 64'(0));
    endtask

    task automatic t_driver();
        drv_valid = 1'b1; drv_src_id_in = 5'h0A;
        @(negedge clk);
        chk("R11 forwards id", 64'(drv_src_id_out), 64'(5'h0A));
        drv_src_id_in = 5'h15;
        @(negedge clk);
        chk("R11 follows new id", 64'(drv_src_id_out), 64'(5'h15));
        drv_valid = 1'b0;
        @(negedge clk);
        chk("R11 idle code when not valid", 64'(drv_src_id_out), 64'(5'h1F));
    endtask

    initial begin
        rst = 1'b1; enable = 1'b1; clr_ovf = 1'b0; pop_ready = 1'b0;
        drv_valid = 1'b0; drv_src_id_in = '0;
        bus_idle();
        @(negedge clk);
        t_reset();
        t_addr();
        t_data();
        t_idle_id();
        t_both();
        t_order();
        t_full_and_disable();
        t_driver();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule